// File: doc/BRIEF.md
# Credit-Flow Flit Link Transmitter

This block sits between a packet source and one direction of a full-duplex on-chip link. The source hands over one 32-bit word per transfer, tagged with a 3-bit kind. The block wraps each accepted word into a 36-bit flit: the word, the kind, and an even-parity bit. It registers the flit onto the link together with a forward strobe and an end-of-packet line. Flow control is done at the sending side. A counter holds the number of free slots in the receiver's input buffer. Each sent flit lowers it by one, and each pulse on the credit-return wire raises it by one, up to the buffer depth. With no credit left, the source is held off.

The link belongs to a single packet from the header flit to the trailer flit. While no packet is open, only a header can open one. While a packet is open, only body and trailer flits go out. Any other flit is consumed and discarded, and it costs no credit. The trailer's data field is not taken from the source. It carries a checksum, the XOR of all body words sent since the header.

The source interface is valid/ready. A transfer happens in a cycle where both `src_valid` and `src_ready` are high. `src_ready` depends only on the offered kind and the current credit. A flit the block would discard is always ready. A flit the block would send is ready only while credit is non-zero. The source must hold its word and kind stable while it waits.

Top module: `flit_link_tx`

## Requirements
- R1: A sent flit has the word in bits 31:0, the kind in bits 34:32 and parity in bit 35. The XOR of all 36 bits is 0. Kind codes: 1 = header, 2 = body, 3 = trailer; any other code is not a sendable kind.
- R2: A flit accepted at a rising edge appears on `lnk_flit` with `lnk_vld` high after that edge. `lnk_vld` is low after any edge at which nothing was sent.
- R3: After reset the credit equals CREDIT_MAX (default 8). A credit return while the credit is already CREDIT_MAX is ignored, so at most CREDIT_MAX flits can go out without a return.
- R4: With zero credit, a sendable flit sees `src_ready` low and nothing is sent. One credit return makes `src_ready` high from the next cycle.
- R5: A send and a credit return in the same cycle leave the credit unchanged.
- R6: With no packet open, a body, trailer or unknown-kind flit is consumed (`src_ready` high) and discarded: nothing is sent and no credit is used.
- R7: With a packet open, a header or unknown-kind flit is consumed and discarded in the same way.
- R8: A trailer goes out with `lnk_last` high. Its data field is the XOR of the body words sent since the header, or 0 if there were none. The source word is ignored, and the packet closes.
- R9: During and after reset, `lnk_vld` and `lnk_last` are low and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Block takes the offered word this cycle |
| src_kind | input | 3 | Flit kind of the offered word |
| src_word | input | 32 | Payload word |
| lnk_flit | output | 36 | Flit on the link: parity, kind, data |
| lnk_vld | output | 1 | Forward strobe: a flit is on the link this cycle |
| lnk_last | output | 1 | End-of-packet line, high with a trailer |
| lnk_credit | input | 1 | Credit-return pulse from the receiver |

## Verification
A credit counter that is one step off does not show up at once. It shows up as `src_ready` falling one flit early or one flit late, at the end of the next run of sends that drains the credit. The bench therefore drains the credit after the mixed-traffic table, after a simultaneous send and return, and after returns made while the credit was full. A wrong packet-open state shows in the same cycle: `lnk_vld` is missing or spurious after the next header, body or trailer. A stale checksum register shows only in the next trailer's data field.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;
  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] K_HEAD = 3'd1;
  localparam logic [KIND_W-1:0] K_BODY = 3'd2;
  localparam logic [KIND_W-1:0] K_TAIL = 3'd3;
endpackage

// File: rtl/flit_credit_ctr.sv
module flit_credit_ctr #(
  parameter int MAX = 8,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          avail
);
  localparam logic [CW-1:0] FULL = CW'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= FULL;
    end else begin
      case ({dec, inc})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   if (cnt != FULL) cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign avail = (cnt != '0);
endmodule

// File: rtl/flit_pkt_ctl.sv
module flit_pkt_ctl
  import flit_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [KIND_W-1:0] src_kind,
  input  logic              credit_ok,
  output logic              src_ready,
  output logic              send,
  output logic              pkt_open
);
  logic sendable;

  // A packet may only open on a header and only body/trailer continue it.
  always_comb begin
    if (pkt_open) sendable = (src_kind == K_BODY) || (src_kind == K_TAIL);
    else          sendable = (src_kind == K_HEAD);
  end

  assign src_ready = !sendable || credit_ok;
  assign send      = src_valid && sendable && credit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
    end else if (send) begin
      if (src_kind == K_HEAD)      pkt_open <= 1'b1;
      else if (src_kind == K_TAIL) pkt_open <= 1'b0;
    end
  end
endmodule

// File: rtl/flit_framer.sv
module flit_framer
  import flit_link_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int FLIT_W = WORD_W + KIND_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [KIND_W-1:0] kind,
  input  logic [WORD_W-1:0] word,
  output logic [FLIT_W-1:0] flit,
  output logic              vld,
  output logic              last
);
  logic [WORD_W-1:0]        xsum;
  logic [WORD_W-1:0]        field;
  logic [WORD_W+KIND_W-1:0] body_bits;

  assign field     = (kind == K_TAIL) ? xsum : word;
  assign body_bits = {kind, field};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flit <= '0;
      vld  <= 1'b0;
      last <= 1'b0;
      xsum <= '0;
    end else begin
      vld  <= send;
      last <= send && (kind == K_TAIL);
      if (send) begin
        flit <= {^body_bits, body_bits};
        if (kind == K_BODY) xsum <= xsum ^ word;
        else                xsum <= '0;
      end
    end
  end
endmodule

// File: rtl/flit_link_tx.sv
module flit_link_tx
  import flit_link_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CREDIT_MAX = 8,
  localparam int FLIT_W    = WORD_W + KIND_W + 1,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [KIND_W-1:0] src_kind,
  input  logic [WORD_W-1:0] src_word,
  output logic [FLIT_W-1:0] lnk_flit,
  output logic              lnk_vld,
  output logic              lnk_last,
  input  logic              lnk_credit
);
  logic [CW-1:0] credit_cnt;
  logic          credit_ok;
  logic          send_fire;
  logic          pkt_open;

  flit_pkt_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_kind  (src_kind),
    .credit_ok (credit_ok),
    .src_ready (src_ready),
    .send      (send_fire),
    .pkt_open  (pkt_open)
  );

  flit_credit_ctr #(.MAX(CREDIT_MAX)) u_crd (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (send_fire),
    .inc   (lnk_credit),
    .cnt   (credit_cnt),
    .avail (credit_ok)
  );

  flit_framer #(.WORD_W(WORD_W)) u_frm (
    .clk   (clk),
    .rst_n (rst_n),
    .send  (send_fire),
    .kind  (src_kind),
    .word  (src_word),
    .flit  (lnk_flit),
    .vld   (lnk_vld),
    .last  (lnk_last)
  );
endmodule

// File: rtl/flit_link_tx_chk.sv
module flit_link_tx_chk #(
  parameter int FLIT_W     = 36,
  parameter int CREDIT_MAX = 8,
  parameter int CW         = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLIT_W-1:0] lnk_flit,
  input logic              lnk_vld,
  input logic              lnk_last,
  input logic [CW-1:0]     credit_cnt,
  input logic              send_fire,
  input logic              lnk_credit,
  input logic              pkt_open
);
  p_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_vld |-> (^lnk_flit == 1'b0));

  p_take_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (send_fire && !lnk_credit) |=> (credit_cnt == $past(credit_cnt) - 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit_cnt <= CW'(CREDIT_MAX));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_cnt == '0) |=> !lnk_vld);

  p_balance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (send_fire && lnk_credit) |=> $stable(credit_cnt));

  p_last_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_last |-> (lnk_vld && lnk_flit[FLIT_W-2 -: 3] == 3'd3 && !pkt_open));
endmodule

bind flit_link_tx flit_link_tx_chk #(
  .FLIT_W(FLIT_W), .CREDIT_MAX(CREDIT_MAX), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lnk_flit   (lnk_flit),
  .lnk_vld    (lnk_vld),
  .lnk_last   (lnk_last),
  .credit_cnt (credit_cnt),
  .send_fire  (send_fire),
  .lnk_credit (lnk_credit),
  .pkt_open   (pkt_open)
);

// File: tb/flit_link_tx_tb.sv
module flit_link_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [2:0]  src_kind = 3'd0;
  logic [31:0] src_word = 32'd0;
  logic [35:0] lnk_flit;
  logic        lnk_vld;
  logic        lnk_last;
  logic        lnk_credit = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_link_tx u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_kind(src_kind), .src_word(src_word), .lnk_flit(lnk_flit),
    .lnk_vld(lnk_vld), .lnk_last(lnk_last), .lnk_credit(lnk_credit)
  );

  // {valid, kind, word, credit_ret, exp_ready, exp_vld, exp_last, exp_kind, exp_data}
  localparam logic [74:0] TBL [NVEC] = '{
    {1'b1, 3'd1, 32'h000000A0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h000000A0}, // R1 header opens
    {1'b1, 3'd2, 32'h11111111, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 32'h11111111}, // R1 body
    {1'b1, 3'd2, 32'h22222222, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 32'h22222222}, // R1 body
    {1'b0, 3'd0, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000000}, // R2 idle cycle, return
    {1'b1, 3'd3, 32'hDEADBEEF, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 32'h33333333}, // R8 checksum trailer
    {1'b1, 3'd2, 32'h00000055, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000000}, // R6 body while closed
    {1'b1, 3'd3, 32'h00000066, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000000}, // R6 trailer while closed
    {1'b1, 3'd1, 32'h0000F00D, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h0000F00D}, // R1 second header
    {1'b1, 3'd1, 32'h00000001, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000000}, // R7 stray header
    {1'b1, 3'd0, 32'h00000002, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000000}, // R7 unknown kind
    {1'b1, 3'd2, 32'h0F0F0F0F, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 32'h0F0F0F0F}, // R5 send with return
    {1'b1, 3'd3, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 32'h0F0F0F0F}  // R8 trailer
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle; returns src_ready as seen before the edge; ends at the following negedge.
  task automatic step(input logic v, input logic [2:0] k, input logic [31:0] d,
                      input logic ret, output logic rdy);
    src_valid = v; src_kind = k; src_word = d; lnk_credit = ret;
    #1 rdy = src_ready;
    @(posedge clk);
    @(negedge clk);
    src_valid = 1'b0; lnk_credit = 1'b0;
  endtask

  task automatic chk_sent(input logic [2:0] k, input logic [31:0] d, input string tag);
    logic [35:0] e;
    e = {^{k, d}, k, d};
    chk(lnk_vld == 1'b1, tag, {63'd0, lnk_vld}, 64'd1);
    chk(lnk_flit == e, tag, {28'd0, lnk_flit}, {28'd0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic rdy;
    logic [74:0] e;
    // R9 reset state
    @(negedge clk);
    @(negedge clk);
    chk(!lnk_vld && !lnk_last, "R9 reset outputs", {62'd0, lnk_vld, lnk_last}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      e = TBL[i];
      step(e[74], e[73:71], e[70:39], e[38], rdy);
      chk(rdy == e[37], $sformatf("R4 R6 ready vec %0d", i), {63'd0, rdy}, {63'd0, e[37]});
      chk(lnk_vld == e[36], $sformatf("R2 R6 R7 vld vec %0d", i), {63'd0, lnk_vld}, {63'd0, e[36]});
      if (e[36]) begin
        chk(lnk_last == e[35], $sformatf("R8 last vec %0d", i), {63'd0, lnk_last}, {63'd0, e[35]});
        chk_sent(e[34:32], e[31:0], $sformatf("R1 R8 flit vec %0d", i));
      end
    end

    // Credit now 3 (R5 kept it at 4 before the final trailer): drain it.
    step(1'b1, 3'd1, 32'h0000ABCD, 1'b0, rdy);
    chk(rdy, "R5 drain 1", {63'd0, rdy}, 64'd1);
    step(1'b1, 3'd2, 32'h00000010, 1'b0, rdy);
    chk(rdy, "R5 drain 2", {63'd0, rdy}, 64'd1);
    step(1'b1, 3'd2, 32'h00000020, 1'b0, rdy);
    chk(rdy, "R5 drain 3", {63'd0, rdy}, 64'd1);
    step(1'b1, 3'd2, 32'h00000030, 1'b0, rdy);
    chk(!rdy, "R4 R5 stall at zero credit", {63'd0, rdy}, 64'd0);
    chk(!lnk_vld, "R4 nothing sent at zero credit", {63'd0, lnk_vld}, 64'd0);
    // R6 a non-sendable flit is still consumed at zero credit
    step(1'b1, 3'd5, 32'h00000040, 1'b0, rdy);
    chk(rdy && !lnk_vld, "R6 R7 unknown kind consumed at zero credit", {62'd0, rdy, lnk_vld}, 64'd2);
    // R4 one return, ready follows next cycle
    step(1'b1, 3'd2, 32'h00000030, 1'b1, rdy);
    chk(!rdy && !lnk_vld, "R4 return cycle still stalled", {62'd0, rdy, lnk_vld}, 64'd0);
    step(1'b1, 3'd2, 32'h00000030, 1'b0, rdy);
    chk(rdy, "R4 ready after return", {63'd0, rdy}, 64'd1);
    chk_sent(3'd2, 32'h00000030, "R4 flit after return");
    step(1'b1, 3'd3, 32'h0, 1'b0, rdy);
    chk(!rdy, "R4 zero again", {63'd0, rdy}, 64'd0);

    // R9 reset mid-packet, then R3 cap
    rst_n = 1'b0;
    #1;
    chk(!lnk_vld && !lnk_last, "R9 async reset outputs", {62'd0, lnk_vld, lnk_last}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 packet closed after reset: a body is discarded
    step(1'b1, 3'd2, 32'h00000077, 1'b0, rdy);
    chk(rdy && !lnk_vld, "R9 closed after reset", {62'd0, rdy, lnk_vld}, 64'd2);
    for (int j = 0; j < 3; j++) step(1'b0, 3'd0, 32'h0, 1'b1, rdy);
    step(1'b1, 3'd1, 32'h00000100, 1'b0, rdy);
    chk(rdy, "R3 send 1", {63'd0, rdy}, 64'd1);
    // R8 trailer with no body words carries 0
    step(1'b1, 3'd3, 32'h12345678, 1'b0, rdy);
    chk(lnk_last, "R8 empty trailer last", {63'd0, lnk_last}, 64'd1);
    chk_sent(3'd3, 32'h0, "R8 empty trailer checksum");
    step(1'b1, 3'd1, 32'h00000200, 1'b0, rdy);
    for (int j = 0; j < 5; j++) begin
      step(1'b1, 3'd2, 32'(j), 1'b0, rdy);
      chk(rdy, $sformatf("R3 send body %0d", j), {63'd0, rdy}, 64'd1);
    end
    step(1'b1, 3'd2, 32'h9, 1'b0, rdy);
    chk(!rdy, "R3 cap holds at CREDIT_MAX", {63'd0, rdy}, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule